// File: doc/BRIEF.md
# Byte-wide OTP Program-and-Verify Sequencer

This block programs a byte-wide one-time-programmable memory one location at a time. A start command launches a walk from location zero up to a final address that is captured from an input when the command arrives. For each location the sequencer looks up the wanted byte on a source input that follows its address output. It then gives the memory a timed active-low program strobe, reads the location back, and repeats the strobe until the byte matches or a fixed pulse budget is spent. A wanted value of all ones needs no programming, because an erased cell already reads as one, so such a location gets no strobe.

When every location up to the final address has been programmed, the sequencer drops the supply select to the nominal read level. It waits for that level to settle, then reads every location once more and compares it with the source. It stops with a sticky done flag, a pass flag, the failing address and the number of strobes spent on it. These results stay valid until the next start command.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset and while done, the program strobe, read enable and chip enable (all active low) are high, and done is 0 after reset.
- R2: A start command while idle or done begins programming at address 0 with supply_prog = 1, and captures last_addr. A start command or a changed last_addr during a run has no effect on the run.
- R3: Before every falling edge of pgm_n, mem_addr and mem_wdata have been unchanged for at least SETUP_CYC cycles. pgm_n then stays low for exactly PULSE_CYC cycles with both held stable.
- R4: During a strobe, ce_n = 0, oe_n = 1 and supply_prog = 1. During any read-back, ce_n = 0 and oe_n = 0 with pgm_n = 1.
- R5: After each strobe the location is read back. A mismatch gives another strobe to the same address, and a match moves on to the next address. A location that matches on its N-th strobe (N ≤ MAX_PULSES) receives exactly N strobes.
- R6: If a location still mismatches after MAX_PULSES strobes, the run ends with done = 1, pass = 0, fail_addr equal to that address and fail_pulses = MAX_PULSES. Later addresses receive no strobe.
- R7: A location whose source byte is 8'hFF receives no strobe.
- R8: After the last address, supply_prog = 0 and every address from 0 to the captured last address is read and compared with src_data. The first mismatch ends the run with pass = 0, fail_addr equal to that address and fail_pulses = 0.
- R9: done, pass, fail_addr and fail_pulses hold their values until the next start command. done falls in the cycle after that command.
- R10: A run with no mismatch in either phase ends with pass = 1, fail_addr = 0 and fail_pulses = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle start command |
| last_addr | input | AW | Final address to program, captured at start |
| src_data | input | 8 | Wanted byte for the current mem_addr |
| mem_rdata | input | 8 | Data read back from the memory |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Data presented for programming |
| pgm_n | output | 1 | Program strobe, active low |
| oe_n | output | 1 | Read enable, active low |
| ce_n | output | 1 | Chip enable, active low |
| supply_prog | output | 1 | 1 selects the programming supply level, 0 the nominal level |
| done | output | 1 | Run finished, sticky until start |
| pass | output | 1 | Run succeeded, valid with done |
| fail_addr | output | AW | Failing address, valid with done |
| fail_pulses | output | PCNT_W | Strobes spent on the failing address; PCNT_W = clog2(MAX_PULSES+1) |

## Verification
A wrong retry count shows within one run as an address that gets a different number of strobes than its cell needs. It also shows as a fail flag reported at the wrong address or with the wrong count. A broken timer shows at the very first strobe as a wrong low width or a short setup window. A wrong address sequence or a lost supply switch shows at the end of the run, through the wrong pass flag or fail address. In the bench the cell model programs only at the program level and one cell reads back wrongly at the nominal level, so these faults change the outcome.

// File: rtl/otp_seq_pkg.sv
// Shared types for the OTP program-and-verify sequencer.
package otp_seq_pkg;

    // Sequencer phases; program phase first, then verify phase.
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SETUP,
        S_PULSE,
        S_READ,
        S_VSETTLE,
        S_VREAD,
        S_DONE
    } seq_state_t;

    // Largest of three durations, used to size the shared timer.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/otp_seq_timer.sv
// Down-counting interval timer shared by all timed phases.
// Assumes: load_val = duration - 1; expired is high in the last cycle of the interval.
module otp_seq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Load a new interval or count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/otp_seq_pulse_ctr.sv
// Counts failed strobes on the current address.
// Assumes: clr is given when a new address begins; at_limit flags the final allowed strobe.
module otp_seq_pulse_ctr #(
    parameter int MAX_PULSES = 25,
    parameter int W          = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_limit
);
    // Clear per address, step once per mismatched read-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    assign at_limit = (count == W'(MAX_PULSES - 1));
endmodule

// File: rtl/otp_seq_addr.sv
// Address walker: captures the final address at start and steps through locations.
// Assumes: start and rewind are never given with step in the same cycle.
module otp_seq_addr #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rewind,
    input  logic          step,
    input  logic [AW-1:0] last_in,
    output logic [AW-1:0] addr,
    output logic          is_last
);
    logic [AW-1:0] last_q;

    // Capture the final address only at the start command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= '0;
        else if (start)
            last_q <= last_in;
    end

    // Rewind to zero at start or phase change, else advance on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (start || rewind)
            addr <= '0;
        else if (step)
            addr <= addr + 1'b1;
    end

    assign is_last = (addr == last_q);
endmodule

// File: rtl/otp_prog_seq.sv
// OTP program-and-verify sequencer top.
// Programs each location with timed strobes and a bounded retry loop, then re-reads
// every location at nominal supply. Assumes src_data follows mem_addr combinationally
// and mem_rdata is valid in the last cycle of a read window.
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int AW         = 17,
    parameter int CLK_HZ     = 100_000_000,
    parameter int PULSE_CYC  = CLK_HZ / 100_000,
    parameter int SETUP_CYC  = 1,
    parameter int READ_CYC   = 1,
    parameter int MAX_PULSES = 25,
    localparam int PCNT_W    = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     last_addr,
    input  logic [7:0]        src_data,
    input  logic [7:0]        mem_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              pgm_n,
    output logic              oe_n,
    output logic              ce_n,
    output logic              supply_prog,
    output logic              done,
    output logic              pass,
    output logic [AW-1:0]     fail_addr,
    output logic [PCNT_W-1:0] fail_pulses
);
    localparam int TMR_W = $clog2(max3(PULSE_CYC, SETUP_CYC, READ_CYC) + 1);
    localparam logic [TMR_W-1:0] T_SETUP = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] T_PULSE = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] T_READ  = TMR_W'(READ_CYC - 1);
    localparam logic [7:0]       ERASED  = 8'hFF;

    seq_state_t        state_q, state_d;
    logic              tmr_load, tmr_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic              a_start, a_rewind, a_step, is_last;
    logic              r_clr, r_inc, at_limit;
    logic [PCNT_W-1:0] r_count;
    logic              wd_load;
    logic [7:0]        wdata_q;
    logic              fin_pass, fin_fail;
    logic [PCNT_W-1:0] fin_pulses;

    otp_seq_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    otp_seq_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .W(PCNT_W)) i_pctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (r_clr),
        .inc      (r_inc),
        .count    (r_count),
        .at_limit (at_limit)
    );

    otp_seq_addr #(.AW(AW)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (a_start),
        .rewind  (a_rewind),
        .step    (a_step),
        .last_in (last_addr),
        .addr    (mem_addr),
        .is_last (is_last)
    );

    // Next-state and per-cycle control strobes.
    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        a_start    = 1'b0;
        a_rewind   = 1'b0;
        a_step     = 1'b0;
        r_clr      = 1'b0;
        r_inc      = 1'b0;
        wd_load    = 1'b0;
        fin_pass   = 1'b0;
        fin_fail   = 1'b0;
        fin_pulses = '0;
        case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_d = S_LOAD;
                    a_start = 1'b1;
                end
            end
            S_LOAD: begin
                if (src_data == ERASED) begin
                    if (is_last) begin
                        state_d  = S_VSETTLE;
                        a_rewind = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = T_SETUP;
                    end else begin
                        a_step = 1'b1;
                    end
                end else begin
                    wd_load  = 1'b1;
                    r_clr    = 1'b1;
                    state_d  = S_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = T_SETUP;
                end
            end
            S_SETUP: begin
                if (tmr_exp) begin
                    state_d  = S_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            S_PULSE: begin
                if (tmr_exp) begin
                    state_d  = S_READ;
                    tmr_load = 1'b1;
                    tmr_val  = T_READ;
                end
            end
            S_READ: begin
                if (tmr_exp) begin
                    if (mem_rdata == wdata_q) begin
                        if (is_last) begin
                            state_d  = S_VSETTLE;
                            a_rewind = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = T_SETUP;
                        end else begin
                            state_d = S_LOAD;
                            a_step  = 1'b1;
                        end
                    end else if (at_limit) begin
                        state_d    = S_DONE;
                        fin_fail   = 1'b1;
                        fin_pulses = PCNT_W'(MAX_PULSES);
                    end else begin
                        state_d  = S_SETUP;
                        r_inc    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = T_SETUP;
                    end
                end
            end
            S_VSETTLE: begin
                if (tmr_exp) begin
                    state_d  = S_VREAD;
                    tmr_load = 1'b1;
                    tmr_val  = T_READ;
                end
            end
            S_VREAD: begin
                if (tmr_exp) begin
                    if (mem_rdata != src_data) begin
                        state_d  = S_DONE;
                        fin_fail = 1'b1;
                    end else if (is_last) begin
                        state_d  = S_DONE;
                        fin_pass = 1'b1;
                    end else begin
                        a_step   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = T_READ;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Hold the byte being programmed so it stays stable across retries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= ERASED;
        else if (wd_load)
            wdata_q <= src_data;
    end

    // Sticky result registers, cleared only by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass        <= 1'b0;
            fail_addr   <= '0;
            fail_pulses <= '0;
        end else if (a_start) begin
            pass        <= 1'b0;
            fail_addr   <= '0;
            fail_pulses <= '0;
        end else if (fin_fail) begin
            pass        <= 1'b0;
            fail_addr   <= mem_addr;
            fail_pulses <= fin_pulses;
        end else if (fin_pass) begin
            pass <= 1'b1;
        end
    end

    // Memory control pins decoded from the phase.
    assign mem_wdata   = wdata_q;
    assign pgm_n       = (state_q != S_PULSE);
    assign oe_n        = !(state_q inside {S_READ, S_VREAD});
    assign ce_n        = !(state_q inside {S_SETUP, S_PULSE, S_READ, S_VSETTLE, S_VREAD});
    assign supply_prog = (state_q inside {S_LOAD, S_SETUP, S_PULSE, S_READ});
    assign done        = (state_q == S_DONE);

    logic unused_ok;
    assign unused_ok = ^r_count;
endmodule

// File: rtl/otp_prog_seq_chk.sv
// Protocol checker for the OTP sequencer pins; attached to every instance by bind.
module otp_prog_seq_chk #(
    parameter int AW         = 17,
    parameter int PCNT_W     = 5,
    parameter int MAX_PULSES = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [AW-1:0]     mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              pgm_n,
    input logic              oe_n,
    input logic              ce_n,
    input logic              supply_prog,
    input logic              done,
    input logic              pass,
    input logic [AW-1:0]     fail_addr,
    input logic [PCNT_W-1:0] fail_pulses
);
    p_quiet_when_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pgm_n && oe_n && ce_n));

    p_setup_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pgm_n) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_n |=> ($stable(mem_addr) && $stable(mem_wdata)));

    p_strobe_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_n |-> (oe_n && !ce_n && supply_prog));

    p_read_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (pgm_n && !ce_n));

    p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fail_pulses <= PCNT_W'(MAX_PULSES)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass) && $stable(fail_addr) && $stable(fail_pulses)));

    p_pass_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (fail_addr == '0 && fail_pulses == '0));
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .AW(AW), .PCNT_W(PCNT_W), .MAX_PULSES(MAX_PULSES)
) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pgm_n(pgm_n), .oe_n(oe_n), .ce_n(ce_n), .supply_prog(supply_prog), .done(done),
    .pass(pass), .fail_addr(fail_addr), .fail_pulses(fail_pulses)
);

// File: tb/test_otp_prog_seq.sv
// Bench: small OTP model with per-cell strobe needs and one weak cell at nominal supply.
module test_otp_prog_seq;
    localparam int AW    = 4;
    localparam int NLOC  = 1 << AW;
    localparam int SETUP = 2;
    localparam int PULSE = 4;
    localparam int READ  = 1;
    localparam int MAXP  = 25;
    localparam int PW    = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0]    src_data, mem_rdata;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [7:0]    mem_wdata;
    logic          pgm_n, oe_n, ce_n, supply_prog, done, pass;
    logic [PW-1:0] fail_pulses;

    logic [7:0] mem  [NLOC];
    logic [7:0] pat  [NLOC];
    int         need [NLOC];
    int         hits [NLOC];
    int         weak_addr = -1;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    otp_prog_seq #(
        .AW(AW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP), .READ_CYC(READ), .MAX_PULSES(MAXP)
    ) i_otp_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .last_addr(last_addr),
        .src_data(src_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .pgm_n(pgm_n), .oe_n(oe_n), .ce_n(ce_n),
        .supply_prog(supply_prog), .done(done), .pass(pass),
        .fail_addr(fail_addr), .fail_pulses(fail_pulses)
    );

    assign src_data  = pat[mem_addr];
    assign mem_rdata = (!ce_n && !oe_n)
        ? (mem[mem_addr] | ((!supply_prog && int'(mem_addr) == weak_addr) ? 8'h01 : 8'h00))
        : 8'h00;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Cell model and pin-timing monitor, sampled away from the active edge.
    bit      prev_pgm = 1'b1;
    int      low_cnt = 0;
    int      stable_cnt = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [7:0]    prev_wd = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_pgm = 1'b1;
            low_cnt = 0;
            stable_cnt = 0;
        end else begin
            stable_cnt = (mem_addr == prev_addr && mem_wdata == prev_wd) ? stable_cnt + 1 : 0;
            if (!pgm_n) begin
                if (prev_pgm) begin
                    chk(stable_cnt >= SETUP, "R3", "setup cycles before strobe", stable_cnt, SETUP);
                    chk(supply_prog && !ce_n && oe_n, "R4", "strobe pin state", supply_prog, 1);
                end
                low_cnt++;
            end else if (!prev_pgm) begin
                chk(low_cnt == PULSE, "R3", "strobe width", low_cnt, PULSE);
                hits[mem_addr]++;
                if (supply_prog && hits[mem_addr] >= need[mem_addr])
                    mem[mem_addr] = mem[mem_addr] & mem_wdata;
                low_cnt = 0;
            end
            if (!oe_n)
                chk(pgm_n && !ce_n, "R4", "read-back pin state", pgm_n, 1);
            prev_pgm  = pgm_n;
            prev_addr = mem_addr;
            prev_wd   = mem_wdata;
        end
    end

    task automatic clear_model();
        for (int a = 0; a < NLOC; a++) begin
            mem[a]  = 8'hFF;
            hits[a] = 0;
            need[a] = 1;
            pat[a]  = 8'hFF;
        end
        weak_addr = -1;
    endtask

    // Launch a run, optionally poke start mid-run, and compare the outcome.
    task automatic run_case(input string name, input int last, input bit poke);
        int fail_at = -1;
        int e_pass, e_fa, e_fp;
        last_addr = AW'(last);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done, "R9", {name, " done drops after start"}, done, 0);
        chk(supply_prog && mem_addr == '0, "R2", {name, " begins at 0 at program level"},
            int'(mem_addr), 0);
        if (poke) begin
            repeat (30) @(negedge clk);
            last_addr = AW'(2);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!done) @(negedge clk);
        for (int a = 0; a <= last; a++)
            if (fail_at < 0 && pat[a] != 8'hFF && need[a] > MAXP) fail_at = a;
        if (fail_at >= 0) begin
            e_pass = 0; e_fa = fail_at; e_fp = MAXP;
        end else if (weak_addr >= 0 && weak_addr <= last) begin
            e_pass = 0; e_fa = weak_addr; e_fp = 0;
        end else begin
            e_pass = 1; e_fa = 0; e_fp = 0;
        end
        chk(pass == e_pass, e_pass ? "R10" : (fail_at >= 0 ? "R6" : "R8"),
            {name, " pass flag"}, pass, e_pass);
        chk(int'(fail_addr) == e_fa, fail_at >= 0 ? "R6" : "R8", {name, " fail address"},
            int'(fail_addr), e_fa);
        chk(int'(fail_pulses) == e_fp, e_pass ? "R10" : "R6", {name, " fail pulses"},
            int'(fail_pulses), e_fp);
        for (int a = 0; a < NLOC; a++) begin
            int e;
            if (a > last || (fail_at >= 0 && a > fail_at) || pat[a] == 8'hFF) e = 0;
            else e = (need[a] > MAXP) ? MAXP : need[a];
            chk(hits[a] == e, pat[a] == 8'hFF ? "R7" : "R5", {name, " strobes per address"},
                hits[a], e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected done");
        report();
    end

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet pins after reset
        chk(pgm_n && oe_n && ce_n, "R1", "pins inactive after reset", {pgm_n, oe_n, ce_n}, 7);
        chk(!done, "R1", "done low after reset", done, 0);

        // R5 R10: every location needs one strobe
        clear_model();
        for (int a = 0; a < NLOC; a++) pat[a] = 8'((a * 37) ^ 8'h5A);
        run_case("single-strobe", NLOC - 1, 1'b0);

        // R5 R7: varied strobe needs, erased bytes skipped, one location at the limit
        clear_model();
        for (int a = 0; a < NLOC; a++) begin
            pat[a]  = (a % 5 == 0) ? 8'hFF : 8'(~(a << 3));
            need[a] = (a % 4) + 1;
        end
        need[3] = MAXP;
        run_case("retry-mix", NLOC - 1, 1'b0);

        // R6: a cell that never programs stops the run
        clear_model();
        for (int a = 0; a < NLOC; a++) pat[a] = 8'(a);
        need[6] = MAXP + 5;
        run_case("stuck-cell", NLOC - 1, 1'b0);

        // R9: results held while idle, start absent, last_addr moved
        last_addr = AW'(1);
        repeat (20) @(negedge clk);
        chk(done && !pass && int'(fail_addr) == 6 && int'(fail_pulses) == MAXP, "R9",
            "result held while idle", int'(fail_addr), 6);
        chk(pgm_n && oe_n && ce_n, "R1", "pins inactive while done", {pgm_n, oe_n, ce_n}, 7);

        // R8: weak cell fails only at nominal supply
        clear_model();
        for (int a = 0; a < NLOC; a++) pat[a] = 8'(8'hA0 + a * 2);
        weak_addr = 9;
        run_case("verify-weak", NLOC - 1, 1'b0);
        chk(mem[15] == pat[15], "R8", "all locations programmed before verify",
            mem[15], pat[15]);

        // R8: weak cell beyond the final address is not read
        clear_model();
        for (int a = 0; a < NLOC; a++) pat[a] = 8'(8'hA0 + a * 2);
        weak_addr = 12;
        run_case("short-range", 11, 1'b0);

        // R2: single location range
        clear_model();
        pat[0] = 8'h00; need[0] = 2;
        run_case("one-location", 0, 1'b0);

        // R2: start and last_addr change during a run are ignored
        clear_model();
        for (int a = 0; a < NLOC; a++) begin
            pat[a] = 8'(8'h33 ^ a);
            need[a] = 2;
        end
        run_case("busy-start", NLOC - 1, 1'b1);

        // R7: all-erased source gives no strobe and passes
        clear_model();
        run_case("all-erased", NLOC - 1, 1'b0);

        report();
    end
endmodule